// File: doc/BRIEF.md
# Gap-Closing Five-Slot Data Pipeline

This block carries 16-bit words through five register slots. A source offers a word with a valid flag. The word enters the first slot when the block is not signalling full upstream. With no stall, every slot moves forward on the same edge, so the block accepts one word per cycle and each word reaches the output five cycles after it is accepted.

When the consumer raises its full input, the word in the last slot stays on the output. Slots behind it do not stop as a unit. Any occupied slot whose successor is empty still moves forward, and new input keeps arriving until all five slots are occupied. The block raises full toward its source only when all five slots hold words and the consumer is still full. That signal is combinational, so the source learns about it in the same cycle that its word would be turned away.

Top module: `bubble_pipe`

## Requirements
- R1: While reset is active and after it is released, with no input offered, all slots are empty: `out_vld` is 0 and `up_full` is 0.
- R2: With `dn_full` low, a word accepted at clock edge k is presented on `out_data` with `out_vld` high after edge k+4. A bench that samples once per cycle therefore sees it five cycles after the cycle in which it was offered.
- R3: With `dn_full` low, the block accepts a word on every cycle and delivers one on every cycle, with no gaps.
- R4: The consumer takes the output word in any cycle in which `out_vld` is high and `dn_full` is low.
- R5: While `out_vld` is high and `dn_full` is high, `out_vld` stays high and `out_data` keeps its value on the next cycle.
- R6: `up_full` is high exactly when `dn_full` is high and all five slots hold a word. In every other case it is low.
- R7: An occupied slot moves its word into an empty following slot even while `dn_full` is high. Starting from empty, with `dn_full` held high, five words offered with any gaps between them are all accepted.
- R8: A word offered while `up_full` is high is not accepted and never appears on the output.
- R9: Every accepted word appears on the output exactly once, in the order of acceptance, under any pattern of `dn_full`.
- R10: A word is accepted in a cycle exactly when `in_vld` is high and `up_full` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. It is released synchronously inside the block. |
| in_data | input | 16 | Word offered by the source |
| in_vld | input | 1 | Marks `in_data` as offered |
| dn_full | input | 1 | Consumer cannot take a word this cycle |
| out_data | output | 16 | Word in the last slot |
| out_vld | output | 1 | Last slot holds a word |
| up_full | output | 1 | Block cannot accept a word this cycle |

## Verification
The assertions check the following on every cycle:
- the output holds steady during a stall;
- an occupied slot always moves its word into an empty successor;
- an offered word enters the first slot whenever `up_full` is low;
- the slot count goes up by one for each accepted word and down by one for each delivered word.

The bench scenarios cover what a per-cycle property cannot show:
- the exact five-cycle latency;
- an unbroken stream with no gaps;
- the point, under a sustained stall, at which full rises after five words that arrived with gaps;
- refusal of a word offered while full;
- the order of delivery across a long, irregular stall pattern, checked against a scoreboard.

// File: rtl/bubble_pipe_pkg.sv
package bubble_pipe_pkg;
  // Default geometry of the pipeline
  localparam int unsigned DEF_DATA_W   = 16;
  localparam int unsigned DEF_STAGES   = 5;
  localparam int unsigned DEF_SYNC_LEN = 2;
endpackage

// File: rtl/bubble_pipe_rst_sync.sv
module bubble_pipe_rst_sync #(
  parameter int unsigned SYNC_LEN = bubble_pipe_pkg::DEF_SYNC_LEN
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [SYNC_LEN-1:0] sync_q;
  logic [SYNC_LEN-1:0] sync_d;

  always_comb sync_d = {sync_q[SYNC_LEN-2:0], 1'b1};

  // Reset asserts at once and is released on a clock edge
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[SYNC_LEN-1];
endmodule

// File: rtl/bubble_pipe_flow.sv
module bubble_pipe_flow #(
  parameter int unsigned STAGES = bubble_pipe_pkg::DEF_STAGES
) (
  input  logic [STAGES-1:0] occ,
  input  logic              dn_full,
  output logic [STAGES-1:0] load,
  output logic              up_full
);
  // A slot may load when it is empty or when its successor loads in the same cycle
  always_comb begin
    logic chain;
    chain = ~occ[STAGES-1] | ~dn_full;
    load[STAGES-1] = chain;
    for (int i = STAGES - 2; i >= 0; i--) begin
      chain   = ~occ[i] | chain;
      load[i] = chain;
    end
  end

  assign up_full = ~load[0];
endmodule

// File: rtl/bubble_pipe_slot.sv
module bubble_pipe_slot #(
  parameter int unsigned DATA_W = bubble_pipe_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              vld_in,
  input  logic [DATA_W-1:0] dat_in,
  output logic              vld_q,
  output logic [DATA_W-1:0] dat_q
);
  logic              vld_d;
  logic              dat_en;

  always_comb begin
    vld_d  = load ? vld_in : vld_q;
    dat_en = load & vld_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // The data register has no reset; its clock enable is written out
  always_ff @(posedge clk) begin
    if (dat_en) dat_q <= dat_in;
  end
endmodule

// File: rtl/bubble_pipe.sv
module bubble_pipe #(
  parameter int unsigned DATA_W   = bubble_pipe_pkg::DEF_DATA_W,
  parameter int unsigned STAGES   = bubble_pipe_pkg::DEF_STAGES,
  parameter int unsigned SYNC_LEN = bubble_pipe_pkg::DEF_SYNC_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_vld,
  input  logic              dn_full,
  output logic [DATA_W-1:0] out_data,
  output logic              out_vld,
  output logic              up_full
);
  localparam int unsigned LAST = STAGES - 1;

  logic              rst_ns;
  logic [STAGES-1:0] occ;
  logic [STAGES-1:0] load;
  logic [STAGES-1:0] vld_in;
  logic [DATA_W-1:0] dat_in [STAGES];
  logic [DATA_W-1:0] dat_q  [STAGES];

  bubble_pipe_rst_sync #(.SYNC_LEN(SYNC_LEN)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_ns)
  );

  bubble_pipe_flow #(.STAGES(STAGES)) u_flow (
    .occ(occ), .dn_full(dn_full), .load(load), .up_full(up_full)
  );

  // Slot 0 is fed from the input; every later slot from its predecessor
  always_comb begin
    vld_in[0] = in_vld;
    dat_in[0] = in_data;
    for (int i = 1; i < STAGES; i++) begin
      vld_in[i] = occ[i-1];
      dat_in[i] = dat_q[i-1];
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_slot
    bubble_pipe_slot #(.DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst_n(rst_ns), .load(load[g]),
      .vld_in(vld_in[g]), .dat_in(dat_in[g]),
      .vld_q(occ[g]), .dat_q(dat_q[g])
    );
  end

  assign out_data = dat_q[LAST];
  assign out_vld  = occ[LAST];

  // ---------------- assertions ----------------
  logic acc_chk;
  logic take_chk;
  assign acc_chk  = in_vld & ~up_full & rst_ns;
  assign take_chk = out_vld & ~dn_full;

  a_r1_reset_empty: assert property (@(posedge clk)
    !rst_ns |-> (!out_vld && !up_full));

  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_ns)
    (out_vld && dn_full) |=> (out_vld && $stable(out_data)));

  a_r6_full_needs_stall: assert property (@(posedge clk) disable iff (!rst_ns)
    up_full |-> dn_full);

  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_ns)
    (in_vld && !up_full) |=> occ[0]);

  a_r9_conserve: assert property (@(posedge clk) disable iff (!rst_ns)
    1'b1 |=> ($countones(occ) == $past($countones(occ))
              + int'($past(acc_chk)) - int'($past(take_chk))));

  for (genvar g = 0; g < STAGES - 1; g++) begin : g_chk
    a_r7_collapse: assert property (@(posedge clk) disable iff (!rst_ns)
      (occ[g] && !occ[g+1]) |=> occ[g+1]);
  end
endmodule

// File: tb/bubble_pipe_tb.sv
module bubble_pipe_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] in_data;
  logic        in_vld;
  logic        dn_full;
  logic [15:0] out_data;
  logic        out_vld;
  logic        up_full;

  int checks = 0;
  int errors = 0;
  logic [15:0] q [$];
  logic seen_vld;
  int delivered;

  always #4 clk = ~clk;

  bubble_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_vld(in_vld),
    .dn_full(dn_full), .out_data(out_data), .out_vld(out_vld), .up_full(up_full)
  );

  task automatic fail(input string req, input int act, input int exp);
    errors++;
    $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  // One cycle: drive inputs, check full (R6) and delivered data (R9), advance
  task automatic cycle(input logic v, input logic [15:0] d, input logic f, output logic acc);
    in_vld = v; in_data = d; dn_full = f;
    #1;
    checks++;
    if (up_full !== (f && q.size() == 5)) fail("R6 up_full", int'(up_full), int'(f && q.size() == 5));
    acc = v && !up_full;
    if (acc) q.push_back(d);
    seen_vld = out_vld;
    if (out_vld && !f) begin
      checks++;
      delivered++;
      if (q.size() == 0) fail("R9 unexpected word", int'(out_data), -1);
      else begin
        if (out_data !== q[0]) fail("R9 order", int'(out_data), int'(q[0]));
        void'(q.pop_front());
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    logic a;
    for (int i = 0; i < 40; i++) cycle(1'b0, 16'h0, 1'b0, a);
    checks++;
    if (q.size() != 0) fail("R9 words lost", q.size(), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_vld = 1'b0; in_data = '0; dn_full = 1'b0;
    #1;
    checks++;
    if (out_vld !== 1'b0 || up_full !== 1'b0) fail("R1 in reset", int'({out_vld, up_full}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_vld !== 1'b0 || up_full !== 1'b0) fail("R1 after release", int'({out_vld, up_full}), 0);
  endtask

  task automatic t_latency();
    logic a;
    int n = 0;
    cycle(1'b1, 16'hA5A5, 1'b0, a);
    checks++;
    if (!a) fail("R10 accept", 0, 1);
    for (int i = 1; i <= 8 && n == 0; i++) begin
      cycle(1'b0, 16'h0, 1'b0, a);
      if (seen_vld) n = i;
    end
    checks++;
    if (n != 5) fail("R2 latency", n, 5);
    drain();
  endtask

  task automatic t_stream();
    logic a;
    int miss = 0;
    delivered = 0;
    for (int i = 0; i < 20; i++) begin
      cycle(1'b1, 16'h1000 + 16'(i), 1'b0, a);
      if (!a) miss++;
    end
    checks++;
    if (miss != 0) fail("R3 stream refused", miss, 0);
    checks++;
    if (delivered != 15) fail("R3/R4 delivered per cycle", delivered, 15);
    drain();
  endtask

  task automatic t_hold();
    logic a;
    logic [15:0] held;
    int bad = 0;
    cycle(1'b1, 16'h5A5A, 1'b0, a);
    for (int i = 0; i < 10 && !out_vld; i++) cycle(1'b0, 16'h0, 1'b1, a);
    held = out_data;
    for (int i = 0; i < 6; i++) begin
      cycle(1'b0, 16'h0, 1'b1, a);
      if (!out_vld || out_data !== held) bad++;
    end
    checks++;
    if (bad != 0) fail("R5 hold", bad, 0);
    checks++;
    if (held !== 16'h5A5A) fail("R5 held word", int'(held), 16'h5A5A);
    drain();
  endtask

  task automatic t_collapse_ignore();
    logic a;
    int accepted = 0;
    int cyc = 0;
    // Sustained stall, words offered with gaps
    while (accepted < 5 && cyc < 40) begin
      if (cyc % 3 != 1) begin
        cycle(1'b1, 16'h2000 + 16'(accepted), 1'b1, a);
        if (a) accepted++;
      end else cycle(1'b0, 16'h0, 1'b1, a);
      cyc++;
    end
    checks++;
    if (accepted != 5) fail("R7 five accepted under stall", accepted, 5);
    in_vld = 1'b0; #1;
    checks++;
    if (up_full !== 1'b1) fail("R6 full with five slots", int'(up_full), 1);
    // Offer a word while full: must be refused
    for (int i = 0; i < 3; i++) begin
      cycle(1'b1, 16'hDEAD, 1'b1, a);
      checks++;
      if (a) fail("R8 accepted while full", 1, 0);
    end
    delivered = 0;
    drain();
    checks++;
    if (delivered != 5) fail("R8 words after release", delivered, 5);
  endtask

  task automatic t_random();
    logic a;
    int in_cnt = 0;
    delivered = 0;
    for (int i = 0; i < 400; i++) begin
      cycle(($urandom % 3) != 0, 16'($urandom), ($urandom % 5) < 2, a);
      if (a) in_cnt++;
    end
    drain();
    checks++;
    if (delivered != in_cnt) fail("R9 count", delivered, in_cnt);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_stream();
    t_hold();
    t_collapse_ignore();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule